// File: doc/BRIEF.md
# Memory Arbiter Event Statistics Counter

This block sits beside a memory arbiter and watches the grant record the arbiter issues each cycle. A record names the winning client and carries its direction (read or write), whether the access missed the open row, whether it closes the row with auto-precharge, two bank-arbitration flags, and three qualifier flags: high priority, timeout and bandwidth. Two independent gather channels each pick one event kind. Each channel can also narrow its count to one client and to records whose chosen qualifier is set or clear. A shared window counter measures how many clock cycles the gather ran, so software can turn the counts into rates.

Software programs the block through a small register port. Registers are addressed by index: 0 is the gather control, 1 the window clock limit, 2 the window clock count (read only), 3 and 4 the control words of channels 0 and 1, and 5 and 6 the event counts of channels 0 and 1. A typical run issues a reset command, writes both channel control words and the limit, and issues an enable command. After the sample time it issues a disable command and reads the three counts.

Gathering is run by a three-state machine. GS_IDLE is entered out of reset and on every reset command. GS_RUN is entered on an enable command from any state. GS_HOLD is entered on a disable command from any state. A clear command keeps the current state. Counting and history tracking happen only in GS_RUN.

Top module: `amon_stats`

## Requirements
- R1: After reset, both event counts and the clock count read 0, the limit reads all ones, and grant records count nothing until an enable command is issued.
- R2: A write to index 0 takes its command from bits 9:8, with these codes: 3 enable (state GS_RUN), 2 disable (state GS_HOLD, all counts frozen), 1 clear (counts zeroed, state and grant history kept), 0 reset (counts and grant history zeroed, state GS_IDLE).
- R3: The window clock count (index 2) increases by one on every clock edge at which the state is GS_RUN. It never rises past the value written to the limit (index 1).
- R4: Channel control bits 23:16 select the event. Code 0 counts every grant, 1 counts reads, 2 writes, 5 grants with bank flag A, 6 grants with bank flag B, 7 row misses, and 8 auto-precharge grants.
- R5: Event code 3 counts a grant whose direction differs from that of the previous grant seen while running.
- R6: Event code 4 counts a grant whose client equals the previous grant's client, so N back-to-back wins by one client add N-1.
- R7: When control bit 26 is set, a channel counts only records whose client ID equals control bits 13:8.
- R8: Control bits 25:24 pick the qualifier (0 high priority, 1 timeout, 2 bandwidth). Bits 29:28 pick the filter mode: 0 no filter, 1 count only when that qualifier is clear, 2 count only when it is set.
- R9: The two channels count independently. Channel 0 reads at index 5 and channel 1 at index 6.
- R10: An event count that has reached all ones stays there instead of wrapping.
- R11: Event codes 9 and above count nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | ADDR_W | Register write index |
| reg_wdata | input | DATA_W | Register write data |
| reg_raddr | input | ADDR_W | Register read index |
| reg_rdata | output | DATA_W | Register read data, combinational from reg_raddr |
| grant_valid | input | 1 | A grant record is present this cycle |
| grant_client | input | CID_W | Winning client ID |
| grant_write | input | 1 | 1 for a write grant, 0 for a read grant |
| grant_row_miss | input | 1 | The grant missed the open row |
| grant_auto_pre | input | 1 | The grant uses auto-precharge |
| grant_bank_a | input | 1 | Bank-arbitration flag A |
| grant_bank_b | input | 1 | Bank-arbitration flag B |
| grant_hp | input | 1 | High-priority qualifier |
| grant_tm | input | 1 | Timeout qualifier |
| grant_bw | input | 1 | Bandwidth qualifier |

## Verification
A grant record presented before a rising edge at which the state is GS_RUN appears in the event count on the read port right after that edge. A command written at an edge takes effect for the next edge. The edge that latches a disable command therefore still counts one window clock and any grant on it. The edge that latches an enable command counts neither. The bench drives every input just after a falling edge, reads the combinational read port shortly afterwards, and takes all counts only after a disable command. Its expected window counts include the one cycle that the disable edge adds.

// File: rtl/amon_pkg.sv
package amon_pkg;

    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_RUN  = 2'd1,
        GS_HOLD = 2'd2
    } gstate_t;

    localparam logic [1:0] CMD_RESET   = 2'd0;
    localparam logic [1:0] CMD_CLEAR   = 2'd1;
    localparam logic [1:0] CMD_DISABLE = 2'd2;
    localparam logic [1:0] CMD_ENABLE  = 2'd3;

    localparam int NUM_EV = 9;
    localparam int EV_ANY   = 0;
    localparam int EV_READ  = 1;
    localparam int EV_WRITE = 2;
    localparam int EV_TURN  = 3;
    localparam int EV_SUCC  = 4;
    localparam int EV_BANKA = 5;
    localparam int EV_BANKB = 6;
    localparam int EV_MISS  = 7;
    localparam int EV_APRE  = 8;

    localparam int IDX_CTRL   = 0;
    localparam int IDX_LIMIT  = 1;
    localparam int IDX_CLOCKS = 2;
    localparam int IDX_CHCTL  = 3;
    localparam int IDX_CHCNT  = 5;

endpackage

// File: rtl/amon_history.sv
module amon_history
    import amon_pkg::*;
#(
    parameter int CID_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              track_i,
    input  logic              wipe_i,
    input  logic              valid_i,
    input  logic [CID_W-1:0]  cid_i,
    input  logic              write_i,
    input  logic              miss_i,
    input  logic              apre_i,
    input  logic              bank_a_i,
    input  logic              bank_b_i,
    output logic [NUM_EV-1:0] ev_o
);

    logic              seen_q;
    logic [CID_W-1:0]  last_cid_q;
    logic              last_wr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q     <= 1'b0;
            last_cid_q <= '0;
            last_wr_q  <= 1'b0;
        end else if (wipe_i) begin
            seen_q     <= 1'b0;
            last_cid_q <= '0;
            last_wr_q  <= 1'b0;
        end else if (track_i && valid_i) begin
            seen_q     <= 1'b1;
            last_cid_q <= cid_i;
            last_wr_q  <= write_i;
        end
    end

    always_comb begin
        ev_o           = '0;
        ev_o[EV_ANY]   = valid_i;
        ev_o[EV_READ]  = valid_i && !write_i;
        ev_o[EV_WRITE] = valid_i && write_i;
        ev_o[EV_TURN]  = valid_i && seen_q && (write_i != last_wr_q);
        ev_o[EV_SUCC]  = valid_i && seen_q && (cid_i == last_cid_q);
        ev_o[EV_BANKA] = valid_i && bank_a_i;
        ev_o[EV_BANKB] = valid_i && bank_b_i;
        ev_o[EV_MISS]  = valid_i && miss_i;
        ev_o[EV_APRE]  = valid_i && apre_i;
    end

    p_wipe_forgets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_i |=> !seen_q);

    p_track_remembers_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (track_i && valid_i && !wipe_i) |=> (seen_q && last_cid_q == $past(cid_i)));

endmodule

// File: rtl/amon_window.sv
module amon_window #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             zero_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] cnt_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (zero_i) begin
            cnt_o <= '0;
        end else if (run_i && (cnt_o < limit_i)) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    p_stop_at_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!zero_i && cnt_o >= limit_i) |=> $stable(cnt_o));

    p_frozen_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!zero_i && !run_i) |=> $stable(cnt_o));

endmodule

// File: rtl/amon_channel.sv
module amon_channel
    import amon_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int CID_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              zero_i,
    input  logic [NUM_EV-1:0] ev_i,
    input  logic [7:0]        ev_sel_i,
    input  logic [CID_W-1:0]  match_cid_i,
    input  logic              cid_en_i,
    input  logic [1:0]        qsel_i,
    input  logic [1:0]        qmode_i,
    input  logic [CID_W-1:0]  rec_cid_i,
    input  logic              hp_i,
    input  logic              tm_i,
    input  logic              bw_i,
    output logic [CNT_W-1:0]  cnt_o
);

    logic ev_hit;
    logic qual_bit;
    logic pri_ok;
    logic cid_ok;
    logic bump;

    always_comb begin
        ev_hit = 1'b0;
        for (int k = 0; k < NUM_EV; k++) begin
            if (ev_sel_i == 8'(k)) ev_hit = ev_i[k];
        end
    end

    always_comb begin
        unique case (qsel_i)
            2'd0:    qual_bit = hp_i;
            2'd1:    qual_bit = tm_i;
            2'd2:    qual_bit = bw_i;
            default: qual_bit = 1'b0;
        endcase
        unique case (qmode_i)
            2'd1:    pri_ok = !qual_bit;
            2'd2:    pri_ok = qual_bit;
            default: pri_ok = 1'b1;
        endcase
    end

    assign cid_ok = !cid_en_i || (rec_cid_i == match_cid_i);
    assign bump   = run_i && ev_hit && cid_ok && pri_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (zero_i) begin
            cnt_o <= '0;
        end else if (bump && (cnt_o != '1)) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    p_saturate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == '1 && !zero_i) |=> (cnt_o == '1));

    p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_i |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1));

    p_no_event_no_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!zero_i && ev_sel_i >= 8'(NUM_EV)) |=> $stable(cnt_o));

endmodule

// File: rtl/amon_stats.sv
module amon_stats
    import amon_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 32,
    parameter int CID_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_waddr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [ADDR_W-1:0] reg_raddr,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              grant_valid,
    input  logic [CID_W-1:0]  grant_client,
    input  logic              grant_write,
    input  logic              grant_row_miss,
    input  logic              grant_auto_pre,
    input  logic              grant_bank_a,
    input  logic              grant_bank_b,
    input  logic              grant_hp,
    input  logic              grant_tm,
    input  logic              grant_bw
);

    localparam int NUM_CH = 2;

    gstate_t           state_q, state_d;
    logic              cmd_wr;
    logic [1:0]        cmd;
    logic [1:0]        last_cmd_q;
    logic              run, zero_ctr, wipe_hist;
    logic [CNT_W-1:0]  limit_q;
    logic [CNT_W-1:0]  clocks;
    logic [DATA_W-1:0] chan_ctl_q [NUM_CH];
    logic [CNT_W-1:0]  chan_cnt   [NUM_CH];
    logic [NUM_EV-1:0] ev_vec;

    assign cmd_wr = reg_we && (reg_waddr == ADDR_W'(IDX_CTRL));
    assign cmd    = reg_wdata[9:8];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GS_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_IDLE, GS_RUN, GS_HOLD: begin
                if (cmd_wr) begin
                    unique case (cmd)
                        CMD_RESET:   state_d = GS_IDLE;
                        CMD_CLEAR:   state_d = state_q;
                        CMD_DISABLE: state_d = GS_HOLD;
                        CMD_ENABLE:  state_d = GS_RUN;
                        default:     state_d = state_q;
                    endcase
                end
            end
            default: state_d = GS_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        run       = (state_q == GS_RUN);
        zero_ctr  = cmd_wr && (cmd == CMD_RESET || cmd == CMD_CLEAR);
        wipe_hist = cmd_wr && (cmd == CMD_RESET);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_cmd_q <= CMD_RESET;
            limit_q    <= '1;
        end else if (reg_we) begin
            if (reg_waddr == ADDR_W'(IDX_CTRL))  last_cmd_q <= cmd;
            if (reg_waddr == ADDR_W'(IDX_LIMIT)) limit_q    <= reg_wdata[CNT_W-1:0];
        end
    end

    amon_history #(.CID_W(CID_W)) u_history (
        .clk      (clk),
        .rst_n    (rst_n),
        .track_i  (run),
        .wipe_i   (wipe_hist),
        .valid_i  (grant_valid),
        .cid_i    (grant_client),
        .write_i  (grant_write),
        .miss_i   (grant_row_miss),
        .apre_i   (grant_auto_pre),
        .bank_a_i (grant_bank_a),
        .bank_b_i (grant_bank_b),
        .ev_o     (ev_vec)
    );

    amon_window #(.CNT_W(CNT_W)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .zero_i  (zero_ctr),
        .limit_i (limit_q),
        .cnt_o   (clocks)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chan_ctl_q[c] <= '0;
            else if (reg_we && reg_waddr == ADDR_W'(IDX_CHCTL + c))
                chan_ctl_q[c] <= reg_wdata;
        end

        amon_channel #(.CNT_W(CNT_W), .CID_W(CID_W)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .run_i       (run),
            .zero_i      (zero_ctr),
            .ev_i        (ev_vec),
            .ev_sel_i    (chan_ctl_q[c][23:16]),
            .match_cid_i (chan_ctl_q[c][8 +: CID_W]),
            .cid_en_i    (chan_ctl_q[c][26]),
            .qsel_i      (chan_ctl_q[c][25:24]),
            .qmode_i     (chan_ctl_q[c][29:28]),
            .rec_cid_i   (grant_client),
            .hp_i        (grant_hp),
            .tm_i        (grant_tm),
            .bw_i        (grant_bw),
            .cnt_o       (chan_cnt[c])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_raddr == ADDR_W'(IDX_CTRL))   reg_rdata[9:8] = last_cmd_q;
        if (reg_raddr == ADDR_W'(IDX_LIMIT))  reg_rdata[CNT_W-1:0] = limit_q;
        if (reg_raddr == ADDR_W'(IDX_CLOCKS)) reg_rdata[CNT_W-1:0] = clocks;
        for (int c = 0; c < NUM_CH; c++) begin
            if (reg_raddr == ADDR_W'(IDX_CHCTL + c)) reg_rdata = chan_ctl_q[c];
            if (reg_raddr == ADDR_W'(IDX_CHCNT + c)) reg_rdata[CNT_W-1:0] = chan_cnt[c];
        end
    end

    p_reset_goes_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd == CMD_RESET) |=> (state_q == GS_IDLE));

    p_enable_goes_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd == CMD_ENABLE) |=> (state_q == GS_RUN));

    p_clear_zeroes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd == CMD_CLEAR) |=> (clocks == '0 && chan_cnt[0] == '0 && chan_cnt[1] == '0));

    p_idle_no_clock_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_IDLE && !cmd_wr) |=> $stable(clocks));

endmodule

// File: tb/test_amon_stats.sv
module test_amon_stats;
    localparam int DW = 32;
    localparam int AW = 3;
    localparam int CW = 8;
    localparam int IW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [AW-1:0] reg_waddr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_raddr = '0;
    logic [DW-1:0] reg_rdata;
    logic g_v = 0, g_w = 0, g_miss = 0, g_ap = 0, g_ba = 0, g_bb = 0;
    logic g_hp = 0, g_tm = 0, g_bw = 0;
    logic [IW-1:0] g_cid = '0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    amon_stats #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW), .CID_W(IW)) i_amon_stats (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .grant_valid(g_v), .grant_client(g_cid), .grant_write(g_w),
        .grant_row_miss(g_miss), .grant_auto_pre(g_ap), .grant_bank_a(g_ba),
        .grant_bank_b(g_bb), .grant_hp(g_hp), .grant_tm(g_tm), .grant_bw(g_bw)
    );

    function automatic logic [31:0] ctl(int ev, int cid, bit fen, int qsel, int mode);
        return (32'(mode) << 28) | (32'(fen) << 26) | (32'(qsel) << 24) |
               (32'(ev) << 16) | (32'(cid) << 8);
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(int addr, logic [31:0] data);
        reg_we = 1'b1; reg_waddr = AW'(addr); reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(int addr, output int val);
        reg_raddr = AW'(addr);
        #1;
        val = int'(reg_rdata);
    endtask

    task automatic grant(int cid, bit w, bit miss = 0, bit ap = 0, bit ba = 0,
                         bit bb = 0, bit hp = 0, bit tm = 0, bit bw = 0);
        g_v = 1; g_cid = IW'(cid); g_w = w; g_miss = miss; g_ap = ap;
        g_ba = ba; g_bb = bb; g_hp = hp; g_tm = tm; g_bw = bw;
        @(negedge clk);
        g_v = 0; g_w = 0; g_miss = 0; g_ap = 0; g_ba = 0; g_bb = 0;
        g_hp = 0; g_tm = 0; g_bw = 0;
    endtask

    task automatic start(logic [31:0] c0, logic [31:0] c1);
        wr(0, 32'h0000_0000);
        wr(3, c0);
        wr(4, c1);
        wr(0, 32'h0000_0300);
    endtask

    task automatic stop();
        wr(0, 32'h0000_0200);
    endtask

    task automatic t_reset_state();
        int v;
        rd(5, v); check("R1 cnt0 after reset", v, 0);
        rd(6, v); check("R1 cnt1 after reset", v, 0);
        rd(2, v); check("R1 clocks after reset", v, 0);
        rd(1, v); check("R1 limit after reset", v, 255);
        wr(3, ctl(0, 0, 0, 0, 0));
        grant(1, 0); grant(2, 1);
        rd(5, v); check("R1 no count while idle", v, 0);
    endtask

    task automatic t_window();
        int v;
        start(ctl(0, 0, 0, 0, 0), ctl(0, 0, 0, 0, 0));
        repeat (10) @(negedge clk);
        stop();
        rd(2, v); check("R3 window clocks", v, 11);
        wr(1, 5);
        start(ctl(0, 0, 0, 0, 0), ctl(0, 0, 0, 0, 0));
        repeat (10) @(negedge clk);
        stop();
        rd(2, v); check("R3 window stops at limit", v, 5);
        wr(1, 255);
    endtask

    task automatic t_direction();
        int v;
        start(ctl(3, 0, 0, 0, 0), ctl(1, 0, 0, 0, 0));
        grant(1, 1); grant(1, 0); grant(2, 0); grant(2, 1); grant(3, 1); grant(3, 0);
        stop();
        rd(5, v); check("R5 direction changes", v, 3);
        rd(6, v); check("R4 reads counted", v, 3);
        start(ctl(2, 0, 0, 0, 0), ctl(0, 0, 0, 0, 0));
        grant(1, 1); grant(1, 0); grant(2, 1); grant(2, 1);
        stop();
        rd(5, v); check("R4 writes counted", v, 3);
        rd(6, v); check("R9 any grant on channel 1", v, 4);
    endtask

    task automatic t_successive();
        int v;
        start(ctl(4, 5, 1, 0, 0), ctl(4, 6, 1, 0, 0));
        repeat (4) grant(5, 0);
        grant(6, 0); grant(5, 0); grant(5, 1);
        stop();
        rd(5, v); check("R6 successive wins client 5", v, 4);
        rd(6, v); check("R7 filtered client 6", v, 0);
        start(ctl(4, 0, 0, 0, 0), ctl(0, 9, 1, 0, 0));
        repeat (4) grant(5, 0);
        grant(6, 0); grant(5, 0); grant(5, 1); grant(9, 0);
        stop();
        rd(5, v); check("R6 successive unfiltered", v, 4);
        rd(6, v); check("R7 client 9 only", v, 1);
    endtask

    task automatic t_priority();
        int v;
        start(ctl(0, 0, 0, 0, 2), ctl(0, 0, 0, 1, 1));
        grant(1, 0, 0, 0, 0, 0, 1, 0, 0);
        grant(1, 0, 0, 0, 0, 0, 0, 0, 1);
        grant(1, 0, 0, 0, 0, 0, 1, 1, 0);
        grant(1, 0, 0, 0, 0, 0, 1, 0, 1);
        stop();
        rd(5, v); check("R8 high priority set", v, 3);
        rd(6, v); check("R8 timeout clear", v, 3);
        start(ctl(0, 0, 0, 2, 2), ctl(0, 0, 0, 2, 0));
        grant(1, 0, 0, 0, 0, 0, 1, 0, 0);
        grant(1, 0, 0, 0, 0, 0, 0, 0, 1);
        grant(1, 0, 0, 0, 0, 0, 1, 1, 0);
        grant(1, 0, 0, 0, 0, 0, 1, 0, 1);
        stop();
        rd(5, v); check("R8 bandwidth set", v, 2);
        rd(6, v); check("R8 filter disabled", v, 4);
    endtask

    task automatic t_flags();
        int v;
        start(ctl(7, 0, 0, 0, 0), ctl(8, 0, 0, 0, 0));
        grant(1, 0, 1, 0, 1, 0); grant(1, 0, 1, 1, 0, 1); grant(1, 0, 0, 1, 0, 1);
        grant(1, 0, 1, 0, 0, 0);
        stop();
        rd(5, v); check("R4 row misses", v, 3);
        rd(6, v); check("R4 auto-precharge", v, 2);
        start(ctl(5, 0, 0, 0, 0), ctl(6, 0, 0, 0, 0));
        grant(1, 0, 1, 0, 1, 0); grant(1, 0, 1, 1, 0, 1); grant(1, 0, 0, 1, 0, 1);
        grant(1, 0, 1, 0, 0, 0);
        stop();
        rd(5, v); check("R4 bank flag A", v, 1);
        rd(6, v); check("R4 bank flag B", v, 2);
        start(ctl(9, 0, 0, 0, 0), ctl(200, 0, 0, 0, 0));
        grant(1, 0, 1, 1, 1, 1); grant(1, 1, 1, 1, 1, 1);
        stop();
        rd(5, v); check("R11 code 9", v, 0);
        rd(6, v); check("R11 code 200", v, 0);
    endtask

    task automatic t_commands();
        int v, c0, ck;
        start(ctl(0, 0, 0, 0, 0), ctl(4, 0, 0, 0, 0));
        grant(3, 0); grant(3, 0);
        stop();
        rd(5, c0); rd(2, ck);
        grant(3, 0); grant(3, 0);
        repeat (3) @(negedge clk);
        rd(5, v); check("R2 disable freezes count", v, c0);
        rd(2, v); check("R2 disable freezes clocks", v, ck);
        wr(0, 32'h0000_0300);
        repeat (4) @(negedge clk);
        stop();
        rd(2, v); check("R2 enable resumes clocks", v, ck + 5);
        wr(0, 32'h0000_0300);
        grant(3, 0);
        wr(0, 32'h0000_0100);
        grant(3, 0);
        stop();
        rd(6, v); check("R2 clear keeps history", v, 1);
        rd(5, v); check("R2 clear zeroes count", v, 1);
        rd(2, v); check("R2 clear zeroes clocks", v, 2);
        start(ctl(0, 0, 0, 0, 0), ctl(4, 0, 0, 0, 0));
        grant(3, 0);
        stop();
        rd(6, v); check("R2 reset wipes history", v, 0);
    endtask

    task automatic t_saturate();
        int v;
        start(ctl(0, 0, 0, 0, 0), ctl(1, 0, 0, 0, 0));
        repeat (300) grant(4, 1);
        stop();
        rd(5, v); check("R10 event count saturates", v, 255);
        rd(6, v); check("R9 channel 1 independent", v, 0);
        rd(2, v); check("R3 clocks saturate", v, 255);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_window();
        t_direction();
        t_successive();
        t_priority();
        t_flags();
        t_commands();
        t_saturate();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule